// File: doc/BRIEF.md
# Packed Indexed-Pixel Unpacker

This block sits between a frame-buffer byte stream and a display pipeline. It takes bytes over a valid/ready handshake and splits each byte into color-index pixels. It emits one pixel per clock, as an 8-bit zero-extended index, under a second valid/ready handshake. A pixel field can be 1, 2, 4 or 8 bits wide. The pixels of a byte are taken either from the top bits downward or from the bottom bits upward.

The pixel ordering belongs to the display side, not to the host's byte order, so it is an explicit configuration input. A one-cycle frame-start pulse latches the depth and the ordering. The same pulse drops any half-used byte, so each frame starts cleanly on a byte boundary.

Control is a two-state machine:
- `ST_EMPTY` means no byte is held.
- `ST_HOLD` means a byte is held and its pixels are being emitted.

Transitions:
- EMPTY→HOLD (`load`): a byte is accepted.
- HOLD→HOLD (`refill`): the last pixel is taken and a new byte is accepted in the same cycle.
- HOLD→EMPTY (`drain`): the last pixel is taken and no byte arrives.
- any→EMPTY (`flush`): frame start.

Top module: `pix_unpack`

## Requirements
- R1: `cfg_depth` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bits per pixel, which give 8, 4, 2 and 1 pixels per byte. Codes 4 to 7 act as code 3 (8 bits per pixel).
- R2: With `cfg_lsb_first`=0, the first pixel of a byte comes from its top field. At 1 bpp the pixels follow bit 7 down to bit 0. At 2 bpp, byte B4h gives 2,3,1,0.
- R3: With `cfg_lsb_first`=1, the first pixel comes from the bottom field. At 2 bpp the fields are taken as bits 1-0, 3-2, 5-4, 7-6. At 4 bpp, byte 3Ch gives Ch and then 3h.
- R4: Inside a pixel field, the higher-numbered bit is the more significant bit of the index in both orderings. `pix_data` is zero-extended, so its bits above the field width are 0.
- R5: Bytes are used in arrival order, and pixel numbering carries on across bytes. At 4 bpp LSB-first, bytes 12h and 34h give 2,1,4,3.
- R6: A byte is accepted only when no byte is held, or in the cycle when the held byte's last pixel is taken. That handover makes a stream with no idle cycle between bytes.
- R7: While `pix_ready` is low, `pix_valid` stays high and `pix_data` holds its value.
- R8: In the cycle of `frame_start`, `in_ready` and `pix_valid` are low. The pulse drops the held byte and resets the pixel position. The new depth and ordering apply from the next byte onward. `pix_valid` is low in the cycle after the pulse.
- R9: After reset, `pix_valid` is low and `in_ready` is high. The configuration is 8 bpp MSB-first until the first frame start.
- R10: A pixel is offered with `pix_valid` high in the cycle right after its byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse: latch configuration, drop held byte |
| cfg_depth | input | 3 | Depth code (R1) |
| cfg_lsb_first | input | 1 | 1: first pixel from bottom bits |
| in_byte | input | 8 | Frame-buffer byte |
| in_valid | input | 1 | Byte is offered |
| in_ready | output | 1 | Byte can be taken |
| pix_data | output | 8 | Zero-extended color index |
| pix_valid | output | 1 | Pixel is offered |
| pix_ready | input | 1 | Downstream takes the pixel |

## Verification
A wrong slot count shows at the ports within one byte, in one of two ways. If the count is off, pixels are lost or repeated: the next byte's first index appears too early, or one index appears twice. If the field selection is wrong, the indices come out swapped or shifted, and the first or second pixel after a load already differs from the table. A wrong state shows up the cycle it happens, as one of these:
- a gap in `pix_valid` during a continuous stream;
- `in_ready` high while the pixels of a byte are still pending;
- a pixel surviving a frame start.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

    typedef enum logic [1:0] {
        PW_1 = 2'd0,
        PW_2 = 2'd1,
        PW_4 = 2'd2,
        PW_8 = 2'd3
    } pix_width_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } unpack_state_e;

    // Codes above the widest map to the widest field.
    function automatic pix_width_e decode_depth(input logic [2:0] code);
        pix_width_e w;
        unique case (code)
            3'd0:    w = PW_1;
            3'd1:    w = PW_2;
            3'd2:    w = PW_4;
            default: w = PW_8;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/pix_cfg_reg.sv
module pix_cfg_reg
    import pix_unpack_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int SLOT_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [2:0]        cfg_depth,
    input  logic              cfg_lsb_first,
    output pix_width_e        width_q,
    output logic              lsb_first_q,
    output logic [SLOT_W-1:0] last_slot
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q     <= PW_8;
            lsb_first_q <= 1'b0;
        end else if (frame_start) begin
            width_q     <= decode_depth(cfg_depth);
            lsb_first_q <= cfg_lsb_first;
        end
    end

    // Pixels per byte minus one.
    assign last_slot = SLOT_W'((BYTE_W >> width_q) - 1);

endmodule

// File: rtl/pix_field_sel.sv
module pix_field_sel #(
    parameter int BYTE_W = 8,
    localparam int SLOT_W = $clog2(BYTE_W),
    localparam int NUM_W  = SLOT_W + 1
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [1:0]        lw_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [SLOT_W-1:0] last_i,
    input  logic              lsb_first_i,
    output logic [BYTE_W-1:0] pix_o
);

    logic [SLOT_W-1:0] fld;
    logic [BYTE_W-1:0] cand [NUM_W];

    // Field index counted from the bottom of the byte.
    assign fld = lsb_first_i ? slot_i : (last_i - slot_i);

    for (genvar g = 0; g < NUM_W; g++) begin : g_width
        localparam int FW = 1 << g;
        localparam logic [BYTE_W-1:0] MASK = BYTE_W'((64'd1 << FW) - 64'd1);
        assign cand[g] = (byte_i >> (32'(fld) * FW)) & MASK;
    end

    assign pix_o = cand[lw_i];

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
    import pix_unpack_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int SLOT_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [2:0]        cfg_depth,
    input  logic              cfg_lsb_first,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [BYTE_W-1:0] pix_data,
    output logic              pix_valid,
    input  logic              pix_ready
);

    unpack_state_e     state_q, state_nx;
    pix_width_e        width_q;
    logic              lsb_first_q;
    logic [SLOT_W-1:0] last_slot;
    logic [SLOT_W-1:0] slot_q;
    logic [BYTE_W-1:0] byte_q;
    logic              pix_take, byte_take, at_last;

    pix_cfg_reg #(.BYTE_W(BYTE_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .cfg_depth    (cfg_depth),
        .cfg_lsb_first(cfg_lsb_first),
        .width_q      (width_q),
        .lsb_first_q  (lsb_first_q),
        .last_slot    (last_slot)
    );

    pix_field_sel #(.BYTE_W(BYTE_W)) u_sel (
        .byte_i      (byte_q),
        .lw_i        (width_q),
        .slot_i      (slot_q),
        .last_i      (last_slot),
        .lsb_first_i (lsb_first_q),
        .pix_o       (pix_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_nx;
    end

    // Held byte and pixel position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            slot_q <= '0;
        end else if (frame_start) begin
            slot_q <= '0;
        end else if (byte_take) begin
            byte_q <= in_byte;
            slot_q <= '0;
        end else if (pix_take) begin
            slot_q <= slot_q + 1'b1;
        end
    end

    // Outputs and next state
    always_comb begin
        at_last   = (slot_q == last_slot);
        pix_valid = (state_q == ST_HOLD) && !frame_start;
        pix_take  = pix_valid && pix_ready;
        in_ready  = !frame_start &&
                    ((state_q == ST_EMPTY) || (at_last && pix_take));
        byte_take = in_valid && in_ready;
        state_nx  = state_q;
        unique case (state_q)
            ST_EMPTY: if (byte_take) state_nx = ST_HOLD;              // load
            ST_HOLD:  if (pix_take && at_last)
                          state_nx = byte_take ? ST_HOLD : ST_EMPTY;  // refill / drain
            default:  state_nx = ST_EMPTY;
        endcase
        if (frame_start) state_nx = ST_EMPTY;                         // flush
    end

endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk
    import pix_unpack_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       frame_start,
    input logic [7:0] in_byte,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] pix_data,
    input logic       pix_valid,
    input logic       pix_ready,
    input pix_width_e width_q
);

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !pix_ready && !frame_start |=>
            frame_start || (pix_valid && $stable(pix_data)));

    // R6
    accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && pix_valid |-> pix_ready);

    // R8
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !pix_valid);

    // R10
    load_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> pix_valid || frame_start);

    // R1
    wide_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && width_q == PW_8 |=> pix_data == $past(in_byte));

    // R4
    zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && width_q == PW_1 |-> pix_data[7:1] == 7'd0);

endmodule

bind pix_unpack pix_unpack_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .in_byte    (in_byte),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .pix_data   (pix_data),
    .pix_valid  (pix_valid),
    .pix_ready  (pix_ready),
    .width_q    (width_q)
);

// File: tb/pix_unpack_bench.sv
module pix_unpack_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic [2:0] cfg_depth = '0;
    logic       cfg_lsb_first = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] pix_data;
    logic       pix_valid;
    logic       pix_ready = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] sb [16];
    logic [7:0] ep [16];

    always #2.5 clk = ~clk;

    pix_unpack u_pix_unpack (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_depth(cfg_depth), .cfg_lsb_first(cfg_lsb_first),
        .in_byte(in_byte), .in_valid(in_valid), .in_ready(in_ready),
        .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready)
    );

    typedef struct packed {
        logic [2:0]  code;
        logic        lsb;
        logic [7:0]  b;
        logic [3:0]  n;
        logic [63:0] px;   // pixel 0 in [63:56]
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{3'd0, 1'b0, 8'hA5, 4'd8, 64'h01_00_01_00_00_01_00_01},
        '{3'd0, 1'b1, 8'h1E, 4'd8, 64'h00_01_01_01_01_00_00_00},
        '{3'd1, 1'b0, 8'hB4, 4'd4, 64'h02_03_01_00_00_00_00_00},
        '{3'd1, 1'b1, 8'hB4, 4'd4, 64'h00_01_03_02_00_00_00_00},
        '{3'd2, 1'b0, 8'h3C, 4'd2, 64'h03_0C_00_00_00_00_00_00},
        '{3'd2, 1'b1, 8'h3C, 4'd2, 64'h0C_03_00_00_00_00_00_00},
        '{3'd3, 1'b0, 8'h9D, 4'd1, 64'h9D_00_00_00_00_00_00_00},
        '{3'd3, 1'b1, 8'h9D, 4'd1, 64'h9D_00_00_00_00_00_00_00},
        '{3'd5, 1'b1, 8'h4E, 4'd1, 64'h4E_00_00_00_00_00_00_00},
        '{3'd7, 1'b0, 8'h81, 4'd1, 64'h81_00_00_00_00_00_00_00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [2:0] code, input logic lsb);
        @(negedge clk);
        frame_start = 1'b1; cfg_depth = code; cfg_lsb_first = lsb;
        in_valid = 1'b0; pix_ready = 1'b0;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    // Feeds sb[0..nb-1], collects np pixels against ep[], ready always high.
    task automatic run_stream(input string req, input int nb, input int np, input bit gap_chk);
        int bi = 0;
        int pi = 0;
        int cyc = 0;
        int gaps = 0;
        bit started = 1'b0;
        bit acc;
        while (pi < np && cyc < 200) begin
            @(negedge clk);
            in_valid  = (bi < nb);
            in_byte   = (bi < nb) ? sb[bi] : 8'h00;
            pix_ready = 1'b1;
            #1;
            acc = in_valid && in_ready;
            if (pix_valid) begin
                started = 1'b1;
                check(req, pix_data, ep[pi]);
                pi++;
            end else if (started) begin
                gaps++;
            end
            if (acc) bi++;
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0; pix_ready = 1'b0;
        if (cyc >= 200) check({req, " stream stalled"}, 32'(pi), 32'(np));
        if (gap_chk) check({req, " idle cycles"}, 32'(gaps), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        check("R9 pix_valid after reset", pix_valid, 1'b0);
        check("R9 in_ready after reset", in_ready, 1'b1);
        sb[0] = 8'h9D; ep[0] = 8'h9D;
        run_stream("R9 default 8bpp", 1, 1, 1'b0);

        // Table of single-byte vectors (R1 R2 R3 R4)
        for (int v = 0; v < 10; v++) begin
            string tag;
            frame(VEC[v].code, VEC[v].lsb);
            sb[0] = VEC[v].b;
            for (int k = 0; k < 8; k++) ep[k] = VEC[v].px[63-8*k -: 8];
            tag = (VEC[v].code > 3'd3) ? "R1" : (VEC[v].lsb ? "R3" : "R2");
            run_stream(tag, 1, int'(VEC[v].n), 1'b1);
        end

        // R5 R6: multi-byte, continuous stream
        frame(3'd2, 1'b1);
        sb[0] = 8'h12; sb[1] = 8'h34;
        ep[0] = 8'h2; ep[1] = 8'h1; ep[2] = 8'h4; ep[3] = 8'h3;
        run_stream("R5 4bpp lsb two bytes", 2, 4, 1'b1);
        frame(3'd1, 1'b0);
        sb[0] = 8'h1B; sb[1] = 8'hE4; sb[2] = 8'h6C;
        ep[0] = 0; ep[1] = 1; ep[2] = 2; ep[3] = 3;
        ep[4] = 3; ep[5] = 2; ep[6] = 1; ep[7] = 0;
        ep[8] = 1; ep[9] = 2; ep[10] = 3; ep[11] = 0;
        run_stream("R6 2bpp msb three bytes", 3, 12, 1'b1);

        // R7 backpressure, and R10 pixel offered right after the load
        frame(3'd2, 1'b0);
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'hA7; pix_ready = 1'b0;
        #1 check("R9 in_ready when empty", in_ready, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        #1 check("R10 valid after load", pix_valid, 1'b1);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk); #1;
            check("R7 valid held", pix_valid, 1'b1);
            check("R7 data held", pix_data, 8'h0A);
            check("R6 no accept mid-byte", in_ready, 1'b0);
        end
        sb[0] = 8'h00;
        ep[0] = 8'h0A; ep[1] = 8'h07;
        run_stream("R7 release", 0, 2, 1'b1);

        // R8 frame start drops a partial byte
        frame(3'd0, 1'b0);
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'hFF;
        @(negedge clk);
        in_valid = 1'b0; pix_ready = 1'b1;
        #1 check("R8 partial first pixel", pix_data, 8'h01);
        @(negedge clk);
        frame_start = 1'b1; cfg_depth = 3'd3; cfg_lsb_first = 1'b0;
        pix_ready = 1'b0; in_valid = 1'b1; in_byte = 8'h77;
        #1;
        check("R8 valid low in pulse", pix_valid, 1'b0);
        check("R8 in_ready low in pulse", in_ready, 1'b0);
        @(negedge clk);
        frame_start = 1'b0; in_valid = 1'b0;
        #1 check("R8 valid low after pulse", pix_valid, 1'b0);
        sb[0] = 8'h5A; ep[0] = 8'h5A;
        run_stream("R8 new config", 1, 1, 1'b0);
        @(negedge clk); #1;
        check("R8 nothing left over", pix_valid, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule